// File: doc/BRIEF.md
# Debug-Link Request Launcher (Test-Clock Side)

This block sits in the test-clock domain of a debug transport. It decides when a request toward the debug module may start, holds that request until the far side answers, and turns the answer into a two-bit result that the data-register capture picks up. It takes one-cycle strobes from the TAP controller for Capture-DR, Shift-DR and Update-DR, the two-bit operation field of the scanned-in word, the dmireset bit of the control/status word, and acknowledge and error lines that have already been synchronized into this clock domain.

A three-state machine runs the link. In Idle, an Update-DR strobe with a valid operation and no sticky result moves it to Requesting. That transition raises the request and the cycle flag together and latches the write flag. In Requesting, an acknowledge or an error drops the request and moves it to Draining. Draining waits for both far-side lines to go low and then returns to Idle. Because the cycle flag stays high through Draining, a late acknowledge can never be taken as the answer to a new request. The result is 00 on acknowledge and 10 on error. It is forced to 11 (busy) when a capture finds the cycle flag high. The sticky flag is re-evaluated only at capture, and only a one-cycle reset pulse derived from the shifted dmireset bit can clear it.

Top module: `dmi_issue_ctrl`

## Requirements
- R1: A request starts only on an Update-DR strobe while the machine is Idle, the sticky flag is low and the operation is 01 or 10 (the XOR of its two bits is 1). On the next cycle `req_o` and `cyc_o` are both 1, and `we_o` is 1 exactly when the operation was 10.
- R2: `req_o` stays high while acknowledge and error are both low. It drops on the cycle after either one is seen.
- R3: After `req_o` drops, `cyc_o` stays high until a cycle in which acknowledge and error are both low. The machine then returns to Idle and `cyc_o` reads 0 on the following cycle.
- R4: An acknowledge in Requesting sets `status_o` to 00. An error sets it to 10.
- R5: A Capture-DR strobe while `cyc_o` is high sets `status_o` to 11 (busy). This holds even when the acknowledge arrives in that same capture cycle.
- R6: `data_we_o` is 1 only during a Capture-DR cycle in which `cyc_o` is low.
- R7: At Capture-DR the sticky flag becomes 1 if the resulting status is 10 or 11, and 0 otherwise. While it is set, Update-DR starts no request.
- R8: The dmireset bit is sampled only while Shift-DR is active. When shifting ends, a set bit gives a single-cycle pulse that clears the sticky flag before the next Update-DR. A set bit seen only outside Shift-DR has no effect.
- R9: When sticky is cleared while `cyc_o` is still high, a following Update-DR starts no new request. `we_o` keeps the value of the outstanding request.
- R10: An operation of 00 or 11 on Update-DR starts no request and leaves `status_o` unchanged.
- R11: After reset, `req_o`, `cyc_o`, `we_o`, `status_o` and `data_we_o` are all 0. `idle_hint_o` always reads 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low test-logic reset, synchronous |
| cap_i | input | 1 | Capture-DR strobe |
| shf_i | input | 1 | Shift-DR strobe |
| upd_i | input | 1 | Update-DR strobe |
| op_i | input | 2 | Operation field: 01 read, 10 write |
| rst_bit_i | input | 1 | dmireset bit of the control/status word |
| ack_i | input | 1 | Synchronized acknowledge from the far side |
| err_i | input | 1 | Synchronized error from the far side |
| req_o | output | 1 | Request toward the far side |
| we_o | output | 1 | Request is a write |
| cyc_o | output | 1 | Link cycle in progress |
| status_o | output | 2 | Result: 00 ok, 10 failed, 11 busy |
| data_we_o | output | 1 | Load result into the data register |
| idle_hint_o | output | 3 | Suggested idle-cycle count, constant 111 |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in the very cycle of Capture-DR. The bench's far-side responder delays its answer by a set number of test-clock cycles. Its run-test-idle gap after Update-DR is sized so that the answer lands exactly on the next capture, which should then read busy and leave the sticky flag set. A second hard case is a dmireset pulse that clears sticky while the link is still draining a slow answer. The bench reaches it by starting a scan in the middle of a long response delay and checking that `we_o` and `req_o` keep the old request's values.

// File: rtl/dmi_issue_pkg.sv
package dmi_issue_pkg;

    typedef enum logic [1:0] {
        LNK_IDLE  = 2'd0,
        LNK_REQ   = 2'd1,
        LNK_DRAIN = 2'd2
    } lnk_state_t;

    localparam int RES_W = 2;

    localparam logic [RES_W-1:0] RES_OK   = 2'b00;
    localparam logic [RES_W-1:0] RES_FAIL = 2'b10;
    localparam logic [RES_W-1:0] RES_BUSY = 2'b11;

endpackage

// File: rtl/dmi_reset_shaper.sv
module dmi_reset_shaper (
    input  logic clk,
    input  logic rst_n,
    input  logic shf_i,
    input  logic bit_i,
    output logic pulse_o
);

    logic armed_q;

    // Bit is followed only while shifting; otherwise forced low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (shf_i) begin
            armed_q <= bit_i;
        end else begin
            armed_q <= 1'b0;
        end
    end

    // High only in the first cycle after shifting ends.
    assign pulse_o = armed_q & ~shf_i;

endmodule

// File: rtl/dmi_launch_fsm.sv
module dmi_launch_fsm
    import dmi_issue_pkg::*;
#(
    parameter int OP_W = 2,
    parameter logic [OP_W-1:0] OP_WRITE = 2'b10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_i,
    input  logic [OP_W-1:0] op_i,
    input  logic            sticky_i,
    input  logic            ack_i,
    input  logic            err_i,
    output logic            req_o,
    output logic            cyc_o,
    output logic            we_o,
    output logic            done_ok_o,
    output logic            done_fail_o
);

    lnk_state_t state_q, state_d;
    logic       we_q;
    logic       op_ok;
    logic       launch;
    logic       answered;
    logic       quiet;

    assign op_ok    = ^op_i;
    assign launch   = upd_i & ~sticky_i & op_ok;
    assign answered = ack_i | err_i;
    assign quiet    = ~ack_i & ~err_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LNK_IDLE:  if (launch)   state_d = LNK_REQ;
            LNK_REQ:   if (answered) state_d = LNK_DRAIN;
            LNK_DRAIN: if (quiet)    state_d = LNK_IDLE;
            default:                 state_d = LNK_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LNK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Direction latched at launch only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q <= 1'b0;
        end else if (state_q == LNK_IDLE && launch) begin
            we_q <= (op_i == OP_WRITE);
        end
    end

    // Outputs
    always_comb begin
        req_o       = 1'b0;
        cyc_o       = 1'b0;
        done_ok_o   = 1'b0;
        done_fail_o = 1'b0;
        unique case (state_q)
            LNK_IDLE: begin
            end
            LNK_REQ: begin
                req_o       = 1'b1;
                cyc_o       = 1'b1;
                done_ok_o   = ack_i;
                done_fail_o = err_i & ~ack_i;
            end
            LNK_DRAIN: begin
                cyc_o = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign we_o = we_q;

endmodule

// File: rtl/dmi_result_track.sv
module dmi_result_track
    import dmi_issue_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic             cyc_i,
    input  logic             done_ok_i,
    input  logic             done_fail_i,
    input  logic             clr_i,
    output logic [RES_W-1:0] status_o,
    output logic             sticky_o,
    output logic             data_we_o
);

    logic [RES_W-1:0] status_q, status_d;
    logic             sticky_q, sticky_d;

    always_comb begin
        status_d = status_q;
        if (cap_i && cyc_i) begin
            status_d = RES_BUSY;
        end else if (done_ok_i) begin
            status_d = RES_OK;
        end else if (done_fail_i) begin
            status_d = RES_FAIL;
        end
    end

    always_comb begin
        sticky_d = sticky_q;
        if (clr_i) begin
            sticky_d = 1'b0;
        end else if (cap_i) begin
            sticky_d = status_d[RES_W-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= RES_OK;
            sticky_q <= 1'b0;
        end else begin
            status_q <= status_d;
            sticky_q <= sticky_d;
        end
    end

    assign status_o  = status_q;
    assign sticky_o  = sticky_q;
    assign data_we_o = cap_i & ~cyc_i;

endmodule

// File: rtl/dmi_issue_ctrl.sv
module dmi_issue_ctrl
    import dmi_issue_pkg::*;
#(
    parameter int OP_W = 2,
    parameter int HINT_W = 3,
    parameter logic [HINT_W-1:0] HINT_VAL = 3'b111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              shf_i,
    input  logic              upd_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic              rst_bit_i,
    input  logic              ack_i,
    input  logic              err_i,
    output logic              req_o,
    output logic              we_o,
    output logic              cyc_o,
    output logic [RES_W-1:0]  status_o,
    output logic              data_we_o,
    output logic [HINT_W-1:0] idle_hint_o
);

    logic sticky_w;
    logic clr_pulse_w;
    logic done_ok_w;
    logic done_fail_w;
    logic cyc_w;

    dmi_reset_shaper u_shaper (
        .clk     (clk),
        .rst_n   (rst_n),
        .shf_i   (shf_i),
        .bit_i   (rst_bit_i),
        .pulse_o (clr_pulse_w)
    );

    dmi_launch_fsm #(
        .OP_W (OP_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_i       (upd_i),
        .op_i        (op_i),
        .sticky_i    (sticky_w),
        .ack_i       (ack_i),
        .err_i       (err_i),
        .req_o       (req_o),
        .cyc_o       (cyc_w),
        .we_o        (we_o),
        .done_ok_o   (done_ok_w),
        .done_fail_o (done_fail_w)
    );

    dmi_result_track u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_i       (cap_i),
        .cyc_i       (cyc_w),
        .done_ok_i   (done_ok_w),
        .done_fail_i (done_fail_w),
        .clr_i       (clr_pulse_w),
        .status_o    (status_o),
        .sticky_o    (sticky_w),
        .data_we_o   (data_we_o)
    );

    assign cyc_o       = cyc_w;
    assign idle_hint_o = HINT_VAL;

endmodule

// File: rtl/dmi_issue_ctrl_chk.sv
module dmi_issue_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cap_i,
    input logic       upd_i,
    input logic [1:0] op_i,
    input logic       ack_i,
    input logic       err_i,
    input logic       req_o,
    input logic       cyc_o,
    input logic [1:0] status_o,
    input logic       sticky,
    input logic       clr_pulse
);

    a_r1_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !sticky && (^op_i) && !cyc_o) |=> (req_o && cyc_o));

    a_r1_only_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_i && !cyc_o) |=> !req_o);

    a_r2_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i && !err_i) |=> req_o);

    a_r2_drop_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && (ack_i || err_i)) |=> !req_o);

    a_r3_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_o && !req_o && (ack_i || err_i)) |=> cyc_o);

    a_r4_err_code: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && err_i && !ack_i && !cap_i) |=> (status_o == 2'b10));

    a_r5_busy_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && cyc_o) |=> (status_o == 2'b11));

    a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_i && !clr_pulse) |=> $stable(sticky));

    a_r7_sticky_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && sticky && !cyc_o) |=> !cyc_o);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> !clr_pulse);

    a_r10_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !(^op_i) && !cyc_o) |=> !req_o);

endmodule

bind dmi_issue_ctrl dmi_issue_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_i     (cap_i),
    .upd_i     (upd_i),
    .op_i      (op_i),
    .ack_i     (ack_i),
    .err_i     (err_i),
    .req_o     (req_o),
    .cyc_o     (cyc_o),
    .status_o  (status_o),
    .sticky    (sticky_w),
    .clr_pulse (clr_pulse_w)
);

// File: tb/dmi_issue_ctrl_tb.sv
module dmi_issue_ctrl_tb;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cap_i = 1'b0, shf_i = 1'b0, upd_i = 1'b0, rst_bit_i = 1'b0;
    logic [1:0] op_i = 2'b00;
    logic       ack_i = 1'b0, err_i = 1'b0;
    logic       req_o, we_o, cyc_o, data_we_o;
    logic [1:0] status_o;
    logic [2:0] idle_hint_o;

    always #(CLK_P/2) clk = ~clk;

    dmi_issue_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cap_i(cap_i), .shf_i(shf_i), .upd_i(upd_i),
        .op_i(op_i), .rst_bit_i(rst_bit_i), .ack_i(ack_i), .err_i(err_i),
        .req_o(req_o), .we_o(we_o), .cyc_o(cyc_o), .status_o(status_o),
        .data_we_o(data_we_o), .idle_hint_o(idle_hint_o)
    );

    typedef struct {
        logic       dwe;
        logic [1:0] st;
        string      tag;
    } cap_exp_t;

    cap_exp_t exp_q[$];
    int n_chk = 0;
    int n_bad = 0;
    int resp_kind = 0;   // 0 acknowledge, 1 error
    int resp_delay = 0;
    int drop_delay = 0;
    bit finished = 1'b0;

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(logic c, logic s, logic u, logic [1:0] op, logic rb);
        @(negedge clk);
        cap_i = c; shf_i = s; upd_i = u; op_i = op; rst_bit_i = rb;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
    endtask

    // capture, two shift cycles, exit, update
    task automatic scan(logic [1:0] op, logic rb_shift, logic rb_out,
                        logic exp_dwe, logic [1:0] exp_st, string tag);
        cap_exp_t e;
        e.dwe = exp_dwe; e.st = exp_st; e.tag = tag;
        exp_q.push_back(e);
        drive(1'b1, 1'b0, 1'b0, 2'b00, rb_out);
        drive(1'b0, 1'b1, 1'b0, 2'b00, rb_shift);
        drive(1'b0, 1'b1, 1'b0, 2'b00, rb_shift);
        drive(1'b0, 1'b0, 1'b0, 2'b00, rb_out);
        drive(1'b0, 1'b0, 1'b1, op, rb_out);
    endtask

    // Monitor: compares each capture against the scoreboard queue
    initial begin
        cap_exp_t e;
        logic dw;
        forever begin
            @(negedge clk);
            #2;
            if (cap_i && rst_n) begin
                dw = data_we_o;
                @(negedge clk);
                #2;
                if (exp_q.size() == 0) begin
                    check("R6 unexpected capture", 8'd1, 8'd0);
                end else begin
                    e = exp_q.pop_front();
                    check({e.tag, " R6 data_we at capture"}, {7'd0, dw}, {7'd0, e.dwe});
                    check({e.tag, " status after capture"}, {6'd0, status_o}, {6'd0, e.st});
                end
            end
        end
    end

    // Far-side responder
    initial begin
        forever begin
            @(negedge clk);
            if (req_o && rst_n) begin
                for (int i = 0; i < resp_delay; i++) @(negedge clk);
                if (resp_kind == 0) ack_i = 1'b1; else err_i = 1'b1;
                do @(negedge clk); while (req_o);
                for (int i = 0; i < drop_delay; i++) @(negedge clk);
                ack_i = 1'b0; err_i = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        #1;
        check("R11 req reset", {7'd0, req_o}, 8'd0);
        check("R11 cyc reset", {7'd0, cyc_o}, 8'd0);
        check("R11 we reset", {7'd0, we_o}, 8'd0);
        check("R11 status reset", {6'd0, status_o}, 8'd0);
        check("R11 data_we reset", {7'd0, data_we_o}, 8'd0);
        check("R11 idle hint", {5'd0, idle_hint_o}, 8'h07);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // A: read acknowledged, slow release
        resp_kind = 0; resp_delay = 0; drop_delay = 2;
        scan(2'b01, 1'b0, 1'b0, 1'b1, 2'b00, "A");
        idle(1); #1;
        check("R1 req after update", {7'd0, req_o}, 8'd1);
        check("R1 cyc after update", {7'd0, cyc_o}, 8'd1);
        check("R1 we for read", {7'd0, we_o}, 8'd0);
        check("R6 no data_we off capture", {7'd0, data_we_o}, 8'd0);
        idle(1); #1;
        check("R2 req drops on ack", {7'd0, req_o}, 8'd0);
        check("R4 status ok", {6'd0, status_o}, 8'd0);
        check("R3 cyc held while ack", {7'd0, cyc_o}, 8'd1);
        idle(2); #1;
        check("R3 cyc held until ack low", {7'd0, cyc_o}, 8'd1);
        idle(1); #1;
        check("R3 cyc clears", {7'd0, cyc_o}, 8'd0);
        idle(1);

        // B: write rejected with error, sticky, reset bit handling
        resp_kind = 1; drop_delay = 0;
        scan(2'b10, 1'b0, 1'b0, 1'b1, 2'b00, "B1");
        idle(1); #1;
        check("R1 we for write", {7'd0, we_o}, 8'd1);
        idle(1); #1;
        check("R4 status fail", {6'd0, status_o}, 8'h02);
        idle(2);
        scan(2'b01, 1'b0, 1'b0, 1'b1, 2'b10, "B2");
        idle(1); #1;
        check("R7 sticky blocks launch", {7'd0, req_o}, 8'd0);
        idle(1);
        scan(2'b01, 1'b0, 1'b1, 1'b1, 2'b10, "B3");
        idle(1); #1;
        check("R8 bit outside shift ignored", {7'd0, req_o}, 8'd0);
        idle(1);
        resp_kind = 0;
        scan(2'b01, 1'b1, 1'b0, 1'b1, 2'b10, "B4");
        idle(1); #1;
        check("R8 pulse clears sticky", {7'd0, req_o}, 8'd1);
        idle(1); #1;
        check("R4 status ok after retry", {6'd0, status_o}, 8'd0);
        idle(2);
        scan(2'b00, 1'b0, 1'b0, 1'b1, 2'b00, "B5");
        idle(1); #1;
        check("R10 op 00 no request", {7'd0, cyc_o}, 8'd0);
        idle(1);

        // C: slow answer, busy capture, sticky cleared while draining
        resp_delay = 12;
        scan(2'b01, 1'b0, 1'b0, 1'b1, 2'b00, "C1");
        idle(2);
        scan(2'b10, 1'b1, 1'b0, 1'b0, 2'b11, "C2 R5 busy");
        idle(1); #1;
        check("R9 no relaunch, we kept", {7'd0, we_o}, 8'd0);
        check("R9 old req still up", {7'd0, req_o}, 8'd1);
        idle(6); #1;
        check("R2 req drops on late ack", {7'd0, req_o}, 8'd0);
        check("R4 status ok late", {6'd0, status_o}, 8'd0);
        idle(1); #1;
        check("R3 cyc clears late", {7'd0, cyc_o}, 8'd0);
        resp_delay = 0;
        scan(2'b01, 1'b0, 1'b0, 1'b1, 2'b00, "C3");
        idle(1); #1;
        check("R1 launch after drain", {7'd0, req_o}, 8'd1);
        idle(4);

        // D: acknowledge lands in the capture cycle
        resp_delay = 2;
        scan(2'b01, 1'b0, 1'b0, 1'b1, 2'b00, "D1");
        idle(2);
        scan(2'b01, 1'b0, 1'b0, 1'b0, 2'b11, "D2 R5 ack at capture");
        idle(1); #1;
        check("R7 busy leaves sticky", {7'd0, req_o}, 8'd0);
        idle(2);
        resp_delay = 0;
        scan(2'b01, 1'b1, 1'b0, 1'b1, 2'b11, "D3");
        idle(1); #1;
        check("R8 recover from busy", {7'd0, req_o}, 8'd1);
        idle(4);
        scan(2'b11, 1'b0, 1'b0, 1'b1, 2'b00, "D4");
        idle(1); #1;
        check("R10 op 11 no request", {7'd0, req_o}, 8'd0);
        idle(2);
        scan(2'b00, 1'b0, 1'b0, 1'b1, 2'b00, "D5 R10 status kept");
        idle(3);

        if (exp_q.size() != 0) check("scoreboard drained", 8'(exp_q.size()), 8'd0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule